// File: doc/BRIEF.md
# Hot-Swap Hardware Fault Monitor

This block watches a hot-swap pass switch and its support parts for damage. It looks for a pass switch shorted from drain to gate or from drain to source, a shorted current-sense resistor, and a timing capacitor that is shorted or too large. Its inputs are digital flags from analog comparators that sit outside the block. It also uses the controller state: regulator good, power-on delay done, enable, gate-source good, breaker trip and primary overcurrent active. When a fault is found it sets a single hardware fault output and keeps it set. Only a sense-resistor short also sends a trip request to the breaker sequencer.

Each fault class has its own arming rule. The switch short checks run while the switch is commanded off. A late drain-source check runs once a settle window has ended after a steady on-state was left. The capacitor checks run at the end of power-on, and again during normal operation unless a primary overcurrent pauses them. All windows are counted in clock cycles. The counts come from the clock rate and from times given in microseconds. The fault output clears only when regulator good falls, or on the synchronous reset.

Top module: `hsw_hwfault_mon`

## Requirements
- R1: When `vreg_good`, `por_done` and not `enable` are all true, no settle window is running and `gate_hi` is high at a clock edge, `hw_fault` is 1 after that edge. With `por_done` low, `gate_hi` has no effect.
- R2: Under the same conditions, `src_hi` high at a clock edge sets `hw_fault` after that edge.
- R3: A steady on-state is recorded when `por_done`, `enable` and `gs_good` are all high. Leaving it, by a falling `enable` or by a `brk_trip` pulse, starts a settle window of SSWIN_US microseconds (WIN_CYC cycles). If `src_hi` is still high in the last cycle of the window, `hw_fault` is set. If `src_hi` is low by then, the fault is not set. The R1 and R2 checks are masked while the window runs.
- R4: On the edge where `por_done` first reads high, `tcap_hi` low sets `hw_fault`. `tcap_hi` high leaves it clear.
- R5: With `por_done`, `enable` and `gs_good` high and no suspension active, `tcap_lo` high sets `hw_fault`. It does not raise `trip_req`.
- R6: Capacitor-low checking is suspended while `poc_active` is high. It stays suspended for REARM_US microseconds (REARM_CYC cycles) after `poc_active` falls, and a new rise restarts the suspension. If `tcap_hi` is low in the last cycle of that period, `hw_fault` is set.
- R7: With `por_done`, `enable` and `gs_good` high, `rshort` high sets `hw_fault` and drives `trip_req` high for exactly one cycle per rising detection.
- R8: Once set, `hw_fault` stays 1 through `enable` toggles and `brk_trip` pulses while `vreg_good` stays high.
- R9: `vreg_good` low at a clock edge, or `rst` high, clears `hw_fault`, `trip_req` and all window state after that edge.
- R10: `trip_req` is raised only by a sense-resistor short, never by a capacitor or switch fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vreg_good | input | 1 | Internal regulator above its lockout level; low clears the latch |
| por_done | input | 1 | Power-on delay has finished |
| enable | input | 1 | Switch-on command |
| gs_good | input | 1 | Switch gate-source voltage is above its good level |
| brk_trip | input | 1 | One-cycle pulse: the breaker tripped for any reason |
| poc_active | input | 1 | Primary overcurrent timing is in progress |
| gate_hi | input | 1 | Gate voltage is above the fault level |
| src_hi | input | 1 | Source voltage is above the fault level |
| rshort | input | 1 | Sense-resistor short comparator |
| tcap_hi | input | 1 | Timing capacitor is above its high threshold |
| tcap_lo | input | 1 | Timing capacitor is below its low threshold |
| hw_fault | output | 1 | Latched hardware fault |
| trip_req | output | 1 | One-cycle trip request to the breaker sequencer |

## Verification
A wrong arming state shows at `hw_fault` one cycle after the triggering input edge. A missed fault leaves the flag low, and a false one sets it while the switch is still on. A wrong window counter moves the late drain-source or re-arm decision by exactly the counting error. The bench model compares every cycle, so an off-by-one appears at the edge of that window. A broken trip edge detector shows as a `trip_req` pulse longer than one cycle, or as a missing pulse, right after `rshort` rises.

// File: rtl/hsw_hwmon_pkg.sv
package hsw_hwmon_pkg;

    // One flag per kind of hardware fault that can set the latch.
    typedef struct packed {
        logic dg;         // drain-gate short while off
        logic ds_now;     // drain-source short while off
        logic ds_late;    // source still high after settle window
        logic cap_por;    // timing cap not charged at end of power-on
        logic cap_low;    // timing cap collapsed during operation
        logic cap_rearm;  // timing cap not recovered after overcurrent
        logic rs;         // sense resistor shorted
    } hw_cause_t;

    // Convert a time in microseconds to clock cycles, at least one.
    function automatic int unsigned us_cycles(input int unsigned khz,
                                              input int unsigned us);
        int unsigned c;
        c = (khz * us) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/hsw_win_timer.sv
module hsw_win_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || abort) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) && !start && !abort;
endmodule

// File: rtl/hsw_switch_chk.sv
module hsw_switch_chk #(
    parameter int unsigned WIN_CYC = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic por_done,
    input  logic enable,
    input  logic gs_good,
    input  logic brk_trip,
    input  logic gate_hi,
    input  logic src_hi,
    output logic dg_set,
    output logic ds_set,
    output logic late_set,
    output logic win_mask
);
    logic en_q;
    logic steady_q;
    logic win_start;
    logic win_busy;
    logic win_done;
    logic idle_chk;

    assign win_start = steady_q && ((en_q && !enable) || brk_trip);

    always_ff @(posedge clk) begin
        if (clr) begin
            en_q     <= 1'b0;
            steady_q <= 1'b0;
        end else begin
            en_q <= enable;
            if (win_start)
                steady_q <= 1'b0;
            else if (por_done && enable && gs_good)
                steady_q <= 1'b1;
        end
    end

    hsw_win_timer #(.CYCLES(WIN_CYC)) u_settle (
        .clk   (clk),
        .clr   (clr),
        .start (win_start),
        .abort (1'b0),
        .busy  (win_busy),
        .done  (win_done)
    );

    assign win_mask = win_busy || win_start;
    assign idle_chk = por_done && !enable && !win_mask;
    assign dg_set   = idle_chk && gate_hi;
    assign ds_set   = idle_chk && src_hi;
    assign late_set = win_done && src_hi;
endmodule

// File: rtl/hsw_cap_chk.sv
module hsw_cap_chk #(
    parameter int unsigned REARM_CYC = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic por_done,
    input  logic enable,
    input  logic gs_good,
    input  logic poc_active,
    input  logic tcap_hi,
    input  logic tcap_lo,
    output logic por_set,
    output logic low_set,
    output logic rearm_set
);
    logic por_q;
    logic poc_q;
    logic rearm_start;
    logic rearm_busy;
    logic rearm_done;
    logic suspend;

    always_ff @(posedge clk) begin
        if (clr) begin
            por_q <= 1'b0;
            poc_q <= 1'b0;
        end else begin
            por_q <= por_done;
            poc_q <= poc_active;
        end
    end

    assign rearm_start = poc_q && !poc_active;

    hsw_win_timer #(.CYCLES(REARM_CYC)) u_rearm (
        .clk   (clk),
        .clr   (clr),
        .start (rearm_start),
        .abort (poc_active),
        .busy  (rearm_busy),
        .done  (rearm_done)
    );

    assign suspend   = poc_active || rearm_start || rearm_busy;
    assign por_set   = por_done && !por_q && !tcap_hi;
    assign low_set   = por_done && enable && gs_good && tcap_lo && !suspend;
    assign rearm_set = rearm_done && !tcap_hi;
endmodule

// File: rtl/hsw_rsense_chk.sv
module hsw_rsense_chk (
    input  logic clk,
    input  logic clr,
    input  logic por_done,
    input  logic enable,
    input  logic gs_good,
    input  logic rshort,
    output logic rs_set,
    output logic trip_req
);
    logic hit;
    logic hit_q;

    assign hit    = por_done && enable && gs_good && rshort;
    assign rs_set = hit;

    always_ff @(posedge clk) begin
        if (clr) begin
            hit_q    <= 1'b0;
            trip_req <= 1'b0;
        end else begin
            hit_q    <= hit;
            trip_req <= hit && !hit_q;
        end
    end
endmodule

// File: rtl/hsw_hwfault_mon.sv
module hsw_hwfault_mon
    import hsw_hwmon_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 25000,
    parameter int unsigned SSWIN_US = 250,
    parameter int unsigned REARM_US = 6500
) (
    input  logic clk,
    input  logic rst,
    input  logic vreg_good,
    input  logic por_done,
    input  logic enable,
    input  logic gs_good,
    input  logic brk_trip,
    input  logic poc_active,
    input  logic gate_hi,
    input  logic src_hi,
    input  logic rshort,
    input  logic tcap_hi,
    input  logic tcap_lo,
    output logic hw_fault,
    output logic trip_req
);
    localparam int unsigned WIN_CYC   = us_cycles(CLK_KHZ, SSWIN_US);
    localparam int unsigned REARM_CYC = us_cycles(CLK_KHZ, REARM_US);

    logic      clr;
    logic      win_mask;
    hw_cause_t cause;

    assign clr = rst || !vreg_good;

    hsw_switch_chk #(.WIN_CYC(WIN_CYC)) u_switch (
        .clk      (clk),
        .clr      (clr),
        .por_done (por_done),
        .enable   (enable),
        .gs_good  (gs_good),
        .brk_trip (brk_trip),
        .gate_hi  (gate_hi),
        .src_hi   (src_hi),
        .dg_set   (cause.dg),
        .ds_set   (cause.ds_now),
        .late_set (cause.ds_late),
        .win_mask (win_mask)
    );

    hsw_cap_chk #(.REARM_CYC(REARM_CYC)) u_cap (
        .clk        (clk),
        .clr        (clr),
        .por_done   (por_done),
        .enable     (enable),
        .gs_good    (gs_good),
        .poc_active (poc_active),
        .tcap_hi    (tcap_hi),
        .tcap_lo    (tcap_lo),
        .por_set    (cause.cap_por),
        .low_set    (cause.cap_low),
        .rearm_set  (cause.cap_rearm)
    );

    hsw_rsense_chk u_rsense (
        .clk      (clk),
        .clr      (clr),
        .por_done (por_done),
        .enable   (enable),
        .gs_good  (gs_good),
        .rshort   (rshort),
        .rs_set   (cause.rs),
        .trip_req (trip_req)
    );

    always_ff @(posedge clk) begin
        if (clr)
            hw_fault <= 1'b0;
        else if (|cause)
            hw_fault <= 1'b1;
    end
endmodule

// File: rtl/hsw_hwfault_mon_sva.sv
module hsw_hwfault_mon_sva (
    input logic clk,
    input logic rst,
    input logic vreg_good,
    input logic por_done,
    input logic enable,
    input logic gate_hi,
    input logic rshort,
    input logic tcap_hi,
    input logic win_mask,
    input logic hw_fault,
    input logic trip_req
);
    // R1
    a_r1_dg_sets: assert property (@(posedge clk) disable iff (rst)
        (vreg_good && por_done && !enable && gate_hi && !win_mask) |=> hw_fault);

    // R4
    a_r4_por_cap: assert property (@(posedge clk) disable iff (rst)
        (vreg_good && $rose(por_done) && !tcap_hi) |=> hw_fault);

    // R7
    a_r7_trip_single: assert property (@(posedge clk) disable iff (rst)
        trip_req |=> !trip_req);

    a_r7_trip_with_fault: assert property (@(posedge clk) disable iff (rst)
        trip_req |-> hw_fault);

    // R8
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (hw_fault && vreg_good) |=> hw_fault);

    // R9
    a_r9_drop_clears: assert property (@(posedge clk) disable iff (rst)
        !vreg_good |=> (!hw_fault && !trip_req));

    // R10
    a_r10_trip_needs_short: assert property (@(posedge clk) disable iff (rst)
        trip_req |-> $past(rshort));
endmodule

bind hsw_hwfault_mon hsw_hwfault_mon_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .vreg_good (vreg_good),
    .por_done  (por_done),
    .enable    (enable),
    .gate_hi   (gate_hi),
    .rshort    (rshort),
    .tcap_hi   (tcap_hi),
    .win_mask  (win_mask),
    .hw_fault  (hw_fault),
    .trip_req  (trip_req)
);

// File: tb/hsw_hwfault_mon_bench.sv
module hsw_hwfault_mon_bench;
    localparam int W  = 25;    // 250 us at 100 kHz
    localparam int RW = 650;   // 6500 us at 100 kHz

    logic clk = 1'b0;
    logic rst, vreg_good, por_done, enable, gs_good, brk_trip, poc_active;
    logic gate_hi, src_hi, rshort, tcap_hi, tcap_lo;
    logic hw_fault, trip_req;

    int total = 0;
    int bad = 0;
    string cur_req = "R9";

    always #2 clk = ~clk;

    hsw_hwfault_mon #(.CLK_KHZ(100), .SSWIN_US(250), .REARM_US(6500)) u_hsw_hwfault_mon (
        .clk(clk), .rst(rst), .vreg_good(vreg_good), .por_done(por_done),
        .enable(enable), .gs_good(gs_good), .brk_trip(brk_trip),
        .poc_active(poc_active), .gate_hi(gate_hi), .src_hi(src_hi),
        .rshort(rshort), .tcap_hi(tcap_hi), .tcap_lo(tcap_lo),
        .hw_fault(hw_fault), .trip_req(trip_req)
    );

    // Behavioural reference model
    bit m_fault, m_trip, m_steady, m_en_q, m_por_q, m_poc_q, m_hit_q;
    int m_win, m_rearm;
    bit ws, rstart, susp, sf, ht;

    always @(posedge clk) begin
        if (rst || !vreg_good) begin
            m_fault = 0; m_trip = 0; m_steady = 0; m_en_q = 0;
            m_por_q = 0; m_poc_q = 0; m_hit_q = 0; m_win = 0; m_rearm = 0;
        end else begin
            sf = 0;
            ws = m_steady && ((m_en_q && !enable) || brk_trip);
            if (por_done && !enable && !(ws || m_win > 0) && (gate_hi || src_hi)) sf = 1;
            if (ws) m_win = W;
            else if (m_win > 0) begin
                if (m_win == 1 && src_hi) sf = 1;
                m_win--;
            end
            if (ws) m_steady = 0;
            else if (por_done && enable && gs_good) m_steady = 1;
            rstart = m_poc_q && !poc_active;
            susp = poc_active || rstart || (m_rearm > 0);
            if (por_done && !m_por_q && !tcap_hi) sf = 1;
            if (por_done && enable && gs_good && tcap_lo && !susp) sf = 1;
            if (poc_active) m_rearm = 0;
            else if (rstart) m_rearm = RW;
            else if (m_rearm > 0) begin
                if (m_rearm == 1 && !tcap_hi) sf = 1;
                m_rearm--;
            end
            ht = por_done && enable && gs_good && rshort;
            if (ht) sf = 1;
            m_trip = ht && !m_hit_q;
            m_hit_q = ht;
            m_fault = m_fault || sf;
            m_en_q = enable; m_por_q = por_done; m_poc_q = poc_active;
        end
    end

    always @(negedge clk) begin
        if (rst === 1'b0) begin
            total++;
            if (hw_fault !== m_fault || trip_req !== m_trip) begin
                bad++;
                $display("FAIL %s model: actual fault=%0b trip=%0b expected fault=%0b trip=%0b",
                         cur_req, hw_fault, trip_req, m_fault, m_trip);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up();
        vreg_good = 0; por_done = 0; enable = 0; gs_good = 0; brk_trip = 0;
        poc_active = 0; gate_hi = 0; src_hi = 0; rshort = 0; tcap_hi = 0; tcap_lo = 0;
        tick(2);
        vreg_good = 1; tcap_hi = 1;
        tick(2);
        por_done = 1;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; vreg_good = 0; por_done = 0; enable = 0; gs_good = 0; brk_trip = 0;
        poc_active = 0; gate_hi = 0; src_hi = 0; rshort = 0; tcap_hi = 0; tcap_lo = 0;
        tick(3);
        chk("R9 reset fault", hw_fault, 1'b0);
        chk("R9 reset trip", trip_req, 1'b0);
        rst = 0;

        cur_req = "R4";
        vreg_good = 1; tcap_hi = 0; tick(2);
        por_done = 1; tick(1);
        chk("R4 cap uncharged at power-on", hw_fault, 1'b1);
        cur_req = "R9";
        vreg_good = 0; por_done = 0; tick(1);
        chk("R9 regulator drop clears", hw_fault, 1'b0);
        cur_req = "R4";
        power_up();
        chk("R4 charged cap no fault", hw_fault, 1'b0);

        cur_req = "R1";
        gate_hi = 1; tick(1);
        chk("R1 drain-gate short", hw_fault, 1'b1);
        power_up();
        vreg_good = 0; por_done = 0; tick(1);
        vreg_good = 1; tcap_hi = 1; gate_hi = 1; tick(3);
        chk("R1 ignored before power-on done", hw_fault, 1'b0);
        gate_hi = 0; por_done = 1; tick(2);
        chk("R1 still clear", hw_fault, 1'b0);

        cur_req = "R2";
        src_hi = 1; tick(1);
        chk("R2 drain-source short", hw_fault, 1'b1);
        power_up();

        cur_req = "R3";
        enable = 1; gs_good = 1; src_hi = 1; tick(3);
        chk("R3 on-state source high no fault", hw_fault, 1'b0);
        enable = 0; gs_good = 0; tick(W - 2);
        chk("R3 no fault inside window", hw_fault, 1'b0);
        tick(4);
        chk("R3 source high at window end", hw_fault, 1'b1);
        power_up();

        enable = 1; gs_good = 1; src_hi = 1; tick(3);
        enable = 0; gs_good = 0; tick(10);
        src_hi = 0; tick(W + 5);
        chk("R3 source low at window end", hw_fault, 1'b0);
        power_up();

        enable = 1; gs_good = 1; tick(3);
        src_hi = 1; brk_trip = 1; tick(1);
        brk_trip = 0; gs_good = 0; tick(W - 3);
        chk("R3 breaker window no early fault", hw_fault, 1'b0);
        tick(4);
        chk("R3 breaker window fault", hw_fault, 1'b1);
        power_up();

        cur_req = "R5";
        enable = 1; gs_good = 1; tick(2);
        tcap_lo = 1; tick(1);
        chk("R5 cap low in operation", hw_fault, 1'b1);
        chk("R10 no trip for cap fault", trip_req, 1'b0);
        power_up();

        cur_req = "R6";
        enable = 1; gs_good = 1; tick(2);
        poc_active = 1; tcap_lo = 1; tcap_hi = 0; tick(5);
        chk("R6 suspended during overcurrent", hw_fault, 1'b0);
        poc_active = 0; tick(RW - 5);
        chk("R6 suspended during re-arm", hw_fault, 1'b0);
        tick(8);
        chk("R6 cap not recovered after re-arm", hw_fault, 1'b1);
        power_up();

        enable = 1; gs_good = 1; tick(2);
        poc_active = 1; tcap_lo = 1; tcap_hi = 0; tick(5);
        poc_active = 0; tick(100);
        tcap_lo = 0; tcap_hi = 1; tick(RW);
        chk("R6 recovered cap no fault", hw_fault, 1'b0);
        power_up();

        cur_req = "R7";
        enable = 1; gs_good = 1; tick(2);
        rshort = 1; tick(1);
        chk("R7 trip request", trip_req, 1'b1);
        chk("R7 fault set", hw_fault, 1'b1);
        tick(1);
        chk("R7 trip one cycle", trip_req, 1'b0);
        tick(3); rshort = 0;

        cur_req = "R8";
        enable = 0; tick(3); enable = 1; tick(3);
        brk_trip = 1; tick(1); brk_trip = 0; tick(2);
        chk("R8 latch holds", hw_fault, 1'b1);

        cur_req = "R7";
        power_up();
        enable = 1; gs_good = 0; rshort = 1; tick(3);
        chk("R7 unarmed no trip", trip_req, 1'b0);
        chk("R7 unarmed no fault", hw_fault, 1'b0);
        rshort = 0; tick(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule